// File: doc/BRIEF.md
# Two-Wire Bus Master with Register-Offset Phase

This block is a single-master controller for the two-wire serial bus. Each transaction it runs moves exactly one data byte to or from a slave. Before the data, it can send a register offset of zero to three bytes. The configuration inputs supply five things:

- a 7-bit device address
- a read/write choice
- an offset length
- a 24-bit offset value
- the byte to write

A single-cycle `start` pulse launches the transaction. The block then produces the whole bus sequence on its own: START, the addressed bytes, repeated START when one is needed, the data phase, and STOP. It reports the end with a one-cycle `done` pulse and a sticky refusal flag.

Both bus lines are open-drain. Each output enable pulls its line low when high and releases it when low. The bench or the pad ring supplies the pull-ups and feeds the SDA level back on `sda_in`. A programmable divider sets the bus clock. Each bit takes four quarter-phases, and every quarter-phase lasts `clk_div+1` system clocks.

Writes follow a fixed order: address with the write bit, the offset bytes, the data byte, then STOP. A read with an offset first writes the offset, then issues a repeated START and the address with the read bit. A read without an offset goes straight to the address with the read bit. The master answers the received byte with a NACK and closes with STOP. Any 10-bit addressing scheme that carries extra address bits in the lowest offset byte is served by the same offset path.

The controller moves through six states:

- `ST_IDLE`: accepts `start`, latches the configuration, and goes to `ST_START`.
- `ST_START`: makes the START condition, then goes to `ST_SHIFT` with the first byte loaded.
- `ST_SHIFT`: moves eight bits, then goes to `ST_ACK`.
- `ST_ACK`: samples the answer and takes one of four exits:
  - to `ST_SHIFT` for the next byte
  - to `ST_RESTART` before the read address
  - to `ST_STOP` after the data byte
  - to `ST_STOP` on a refusal
- `ST_RESTART`: makes the repeated START, then goes to `ST_SHIFT`.
- `ST_STOP`: makes the STOP condition, then returns to `ST_IDLE` with `done`.

Top module: `i2c_am_master`

## Requirements
- R1: After reset, `busy`, `done` and `nack_err` are 0, and both `scl_oe` and `sda_oe` are 0 (lines released). Whenever the block is not busy, both enables stay 0.
- R2: `start` is accepted only when `busy` is 0. A `start` pulse while busy has no effect on the bytes sent, and no second transaction follows.
- R3: Bytes go out MSB first. The first byte after START is `{dev_addr, rw}`, where rw=0 means write and rw=1 means read. The rw bit is 1 only for a read with `iaddr_len`=0.
- R4: `iaddr_len` (0..3) sets how many offset bytes follow the first address byte. They are sent from the highest selected byte down: len 3 sends bits 23:16, 15:8, 7:0; len 2 sends 15:8, 7:0; len 1 sends 7:0; len 0 sends none.
- R5: A write sends `wr_data` after the offset bytes, then STOP. There is exactly one START and one STOP.
- R6: A read with `iaddr_len`>0 sends the offset bytes, then a repeated START, then `{dev_addr,1}`. There are two STARTs and one STOP.
- R7: A read with `iaddr_len`=0 has one START, and its first byte carries rw=1.
- R8: After the received data byte, the master leaves SDA released in the acknowledge slot (NACK) and issues STOP. `rd_data` shows the received byte from `done` until the next accepted `start`.
- R9: If the slave leaves SDA high in the acknowledge slot of any byte it must acknowledge, the block goes straight to STOP. `nack_err` rises together with `done`, stays set, and clears when the next `start` is accepted.
- R10: Apart from START and STOP, SDA changes only while SCL is low. Successive SCL rising edges are 4*(`clk_div`+1) system clocks apart.
- R11: `busy` is 1 from the cycle after an accepted `start` until `done`. `done` is a single-cycle pulse, and `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only when idle |
| rd_req | input | 1 | 1 = read transaction, 0 = write |
| dev_addr | input | 7 | Slave device address |
| iaddr_len | input | 2 | Number of offset bytes, 0 to 3 |
| iaddr | input | 24 | Offset value; low-order bytes used |
| wr_data | input | 8 | Byte sent by a write |
| clk_div | input | DIV_W | Quarter-bit length minus one, in clocks |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| nack_err | output | 1 | Sticky refusal flag |
| rd_data | output | 8 | Byte received by a read |

## Verification
The hardest cases to reach are a refusal on a byte in the middle of the offset phase, and the repeated START between the offset and the read address. Neither can be forced from the master's own pins. The bench therefore models a slave on the wired-AND lines. The slave decodes START and STOP, counts the bytes it receives, and withholds the acknowledge on a byte index chosen by each scenario. It also drives its read byte only after an address carrying the read bit. A line monitor counts SDA changes made while SCL is high and measures the spacing of SCL rising edges, so R10 is checked from the lines alone.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_BYTES = 3;
    localparam int OFS_W = BYTE_W * OFS_BYTES;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SHIFT,
        ST_ACK,
        ST_RESTART,
        ST_STOP
    } state_t;

    // what the byte currently on the wire means
    typedef enum logic [2:0] {
        BK_DEVW,
        BK_IA2,
        BK_IA1,
        BK_IA0,
        BK_DATAW,
        BK_DEVR,
        BK_DATAR
    } kind_t;

    function automatic kind_t first_kind(input logic rd, input logic [1:0] len);
        kind_t k;
        k = (rd && len == 2'd0) ? BK_DEVR : BK_DEVW;
        return k;
    endfunction

    function automatic kind_t next_kind(input kind_t k, input logic rd, input logic [1:0] len);
        kind_t r;
        case (k)
            BK_DEVW: begin
                case (len)
                    2'd3:    r = BK_IA2;
                    2'd2:    r = BK_IA1;
                    2'd1:    r = BK_IA0;
                    default: r = rd ? BK_DEVR : BK_DATAW;
                endcase
            end
            BK_IA2:  r = BK_IA1;
            BK_IA1:  r = BK_IA0;
            BK_IA0:  r = rd ? BK_DEVR : BK_DATAW;
            BK_DEVR: r = BK_DATAR;
            default: r = BK_DATAR;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/i2c_am_tick.sv
module i2c_am_tick #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         smp_en,
    input  logic         sda_in,
    input  logic         shf_en,
    output logic         out_bit,
    output logic         samp,
    output logic [W-1:0] data
);

    logic [W-1:0] sh;
    logic         smp_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh    <= '1;
            smp_r <= 1'b1;
        end else begin
            if (ld) begin
                sh <= ld_val;
            end else if (shf_en) begin
                sh <= {sh[W-2:0], smp_r};
            end
            if (smp_en) begin
                smp_r <= sda_in;
            end
        end
    end

    assign out_bit = sh[W-1];
    assign samp    = smp_r;
    assign data    = sh;

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
    import i2c_am_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [6:0]        dev_addr,
    input  logic [1:0]        iaddr_len,
    input  logic [OFS_W-1:0]  iaddr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              tick,
    input  logic              samp,
    input  logic              sh_bit,
    input  logic [BYTE_W-1:0] sh_data,
    output logic              run,
    output logic              ld,
    output logic [BYTE_W-1:0] ld_val,
    output logic              smp_en,
    output logic              shf_en,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              done,
    output logic              nack_err,
    output logic [BYTE_W-1:0] rd_data
);

    state_t st, st_n;
    kind_t  kind, kind_n;
    logic [1:0] q;
    logic [2:0] bcnt;
    logic       c_rd;
    logic [6:0] c_dev;
    logic [1:0] c_len;
    logic [OFS_W-1:0]  c_ia;
    logic [BYTE_W-1:0] c_wd;
    logic err_pend, err_set, fin, rd_cap;
    logic last_q;

    assign last_q = tick && (q == 2'd3);
    assign run    = (st != ST_IDLE);
    assign smp_en = tick && (q == 2'd2) && (st == ST_SHIFT || st == ST_ACK);
    assign shf_en = last_q && (st == ST_SHIFT);

    // next state and sequencing decisions
    always_comb begin
        st_n    = st;
        kind_n  = kind;
        ld      = 1'b0;
        fin     = 1'b0;
        err_set = 1'b0;
        rd_cap  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) st_n = ST_START;
            end
            ST_START: begin
                if (last_q) begin
                    st_n   = ST_SHIFT;
                    kind_n = first_kind(c_rd, c_len);
                    ld     = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last_q && bcnt == 3'd7) st_n = ST_ACK;
            end
            ST_ACK: begin
                if (last_q) begin
                    if (kind == BK_DATAR) begin
                        rd_cap = 1'b1;
                        st_n   = ST_STOP;
                    end else if (samp) begin
                        err_set = 1'b1;
                        st_n    = ST_STOP;
                    end else if (kind == BK_DATAW) begin
                        st_n = ST_STOP;
                    end else begin
                        kind_n = next_kind(kind, c_rd, c_len);
                        if (kind_n == BK_DEVR) begin
                            st_n = ST_RESTART;
                        end else begin
                            st_n = ST_SHIFT;
                            ld   = 1'b1;
                        end
                    end
                end
            end
            ST_RESTART: begin
                if (last_q) begin
                    st_n = ST_SHIFT;
                    ld   = 1'b1;
                end
            end
            ST_STOP: begin
                if (last_q) begin
                    st_n = ST_IDLE;
                    fin  = 1'b1;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // byte to put on the wire for the kind being entered
    always_comb begin
        unique case (kind_n)
            BK_DEVW:  ld_val = {c_dev, 1'b0};
            BK_DEVR:  ld_val = {c_dev, 1'b1};
            BK_IA2:   ld_val = c_ia[23:16];
            BK_IA1:   ld_val = c_ia[15:8];
            BK_IA0:   ld_val = c_ia[7:0];
            BK_DATAW: ld_val = c_wd;
            default:  ld_val = '1;
        endcase
    end

    // state register and per-transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= BK_DEVW;
            q        <= 2'd0;
            bcnt     <= 3'd0;
            c_rd     <= 1'b0;
            c_dev    <= '0;
            c_len    <= '0;
            c_ia     <= '0;
            c_wd     <= '0;
            err_pend <= 1'b0;
            done     <= 1'b0;
            nack_err <= 1'b0;
            rd_data  <= '0;
        end else begin
            st   <= st_n;
            kind <= kind_n;
            done <= fin;
            if (st == ST_IDLE) begin
                q    <= 2'd0;
                bcnt <= 3'd0;
                if (start) begin
                    c_rd     <= rd_req;
                    c_dev    <= dev_addr;
                    c_len    <= iaddr_len;
                    c_ia     <= iaddr;
                    c_wd     <= wr_data;
                    err_pend <= 1'b0;
                    nack_err <= 1'b0;
                end
            end else if (tick) begin
                q <= q + 2'd1;
                if (shf_en) bcnt <= bcnt + 3'd1;
            end
            if (err_set) err_pend <= 1'b1;
            if (fin)     nack_err <= err_pend;
            if (rd_cap)  rd_data  <= sh_data;
        end
    end

    // line drive per state and quarter-phase (1 = pull low)
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            ST_START: begin
                scl_oe = (q == 2'd3);
                sda_oe = (q != 2'd0);
            end
            ST_RESTART: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = (q[1] == 1'b1);
            end
            ST_SHIFT: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = (kind != BK_DATAR) && !sh_bit;
            end
            ST_ACK: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = 1'b0;
            end
            ST_STOP: begin
                scl_oe = (q == 2'd0);
                sda_oe = (q[1] == 1'b0);
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/i2c_am_master.sv
module i2c_am_master
    import i2c_am_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rd_req,
    input  logic [6:0]       dev_addr,
    input  logic [1:0]       iaddr_len,
    input  logic [23:0]      iaddr,
    input  logic [7:0]       wr_data,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic [7:0]       rd_data
);

    logic run, tick, ld, smp_en, shf_en, sh_bit, samp;
    logic [BYTE_W-1:0] ld_val, sh_data;

    i2c_am_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .div   (clk_div),
        .tick  (tick)
    );

    i2c_am_shift #(.W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld),
        .ld_val  (ld_val),
        .smp_en  (smp_en),
        .sda_in  (sda_in),
        .shf_en  (shf_en),
        .out_bit (sh_bit),
        .samp    (samp),
        .data    (sh_data)
    );

    i2c_am_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .rd_req    (rd_req),
        .dev_addr  (dev_addr),
        .iaddr_len (iaddr_len),
        .iaddr     (iaddr),
        .wr_data   (wr_data),
        .tick      (tick),
        .samp      (samp),
        .sh_bit    (sh_bit),
        .sh_data   (sh_data),
        .run       (run),
        .ld        (ld),
        .ld_val    (ld_val),
        .smp_en    (smp_en),
        .shf_en    (shf_en),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .done      (done),
        .nack_err  (nack_err),
        .rd_data   (rd_data)
    );

    assign busy = run;

endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       nack_err,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] rd_data
);

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_err_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack_err) |-> done);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_err && !(start && !busy)) |=> nack_err);

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(rd_data));

endmodule

bind i2c_am_master i2c_am_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .nack_err (nack_err),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rd_data  (rd_data)
);

// File: tb/tb_i2c_am_master.sv
`timescale 1ns/1ps
module tb_i2c_am_master;
    localparam int DIV_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic rd_req = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [1:0] iaddr_len = '0;
    logic [23:0] iaddr = '0;
    logic [7:0] wr_data = '0;
    logic [DIV_W-1:0] clk_div = 12'd3;
    logic sda_in, scl_oe, sda_oe, busy, done, nack_err;
    logic [7:0] rd_data;

    logic s_oe = 1'b0;
    logic scl_l, sda_l;
    assign scl_l  = !scl_oe;
    assign sda_l  = !(sda_oe || s_oe);
    assign sda_in = sda_l;

    always #10 clk = ~clk;

    i2c_am_master #(.DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
        .dev_addr(dev_addr), .iaddr_len(iaddr_len), .iaddr(iaddr),
        .wr_data(wr_data), .clk_div(clk_div), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done),
        .nack_err(nack_err), .rd_data(rd_data)
    );

    int nvec = 0;
    int nfail = 0;

    // slave model and line monitor
    int mode = 0, cnt = 0, nlog = 0, nstart = 0, nstop = 0, nhi = 0;
    int nack_at = -1, cyc = 0, last_rise = 0, nrise = 0, pmin = 0, pmax = 0;
    logic [7:0] rsh = '0, txsh = '0, rdval = '0;
    logic [7:0] log_b [8];
    logic m_ack = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1;
    logic ack_ok = 1'b1, go_tx = 1'b0, first_b = 1'b0;

    always @(negedge clk) begin
        logic cs, cd;
        cs = scl_l;
        cd = sda_l;
        cyc++;
        if (prev_scl && cs && (cd != prev_sda)) nhi++;
        if (prev_scl && cs && prev_sda && !cd) begin
            nstart++; mode = 1; cnt = 0; s_oe = 1'b0; first_b = 1'b1;
        end else if (prev_scl && cs && !prev_sda && cd) begin
            nstop++; mode = 0; s_oe = 1'b0;
        end else if (!prev_scl && cs) begin
            if (nrise > 0) begin
                if (pmin == 0 || cyc - last_rise < pmin) pmin = cyc - last_rise;
                if (cyc - last_rise > pmax) pmax = cyc - last_rise;
            end
            nrise++;
            last_rise = cyc;
            if (mode == 1) begin rsh = {rsh[6:0], cd}; cnt++; end
            else if (mode == 3) cnt++;
            else if (mode == 4) begin m_ack = cd; mode = 0; end
        end else if (prev_scl && !cs) begin
            if (mode == 1 && cnt == 8) begin
                if (nlog < 8) log_b[nlog] = rsh;
                ack_ok = (nlog != nack_at);
                go_tx = first_b && rsh[0];
                first_b = 1'b0;
                nlog++;
                s_oe = ack_ok;
                mode = 2;
            end else if (mode == 2) begin
                s_oe = 1'b0;
                if (!ack_ok) mode = 0;
                else if (go_tx) begin
                    mode = 3; cnt = 0; txsh = rdval; s_oe = !txsh[7];
                end else begin
                    mode = 1; cnt = 0;
                end
            end else if (mode == 3) begin
                if (cnt == 8) begin mode = 4; s_oe = 1'b0; end
                else s_oe = !txsh[7-cnt];
            end
        end
        prev_scl = cs;
        prev_sda = cd;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic rd, input logic [6:0] dev, input logic [1:0] len,
                          input logic [23:0] ia, input logic [7:0] wd, input int nidx,
                          input logic [7:0] rdv);
        @(negedge clk);
        nlog = 0; nstart = 0; nstop = 0; nhi = 0; nrise = 0; pmin = 0; pmax = 0;
        m_ack = 1'b0; nack_at = nidx; rdval = rdv;
        rd_req = rd; dev_addr = dev; iaddr_len = len; iaddr = ia; wr_data = wd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", busy, 1);
        chk("R9 flag cleared on start", nack_err, 0);
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done) begin seen = 1; break; end
        end
        chk("R11 done reached", seen, 1);
        if (seen) begin
            chk("R11 busy low at done", busy, 0);
            @(negedge clk);
            chk("R11 done one cycle", done, 0);
        end
    endtask

    task automatic check_bytes(input string tag, input logic [7:0] e [8], input int n);
        chk({tag, " byte count"}, nlog, n);
        for (int k = 0; k < n && k < 8; k++) chk(tag, log_b[k], e[k]);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 nack_err", nack_err, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_write(input logic [6:0] dev, input logic [1:0] len,
                           input logic [23:0] ia, input logic [7:0] wd);
        logic [7:0] e [8];
        int n = 0;
        launch(1'b0, dev, len, ia, wd, -1, 8'h00);
        wait_done();
        e[n++] = {dev, 1'b0};
        for (int k = int'(len); k >= 1; k--) e[n++] = ia[8*(k-1) +: 8];
        e[n++] = wd;
        check_bytes("R3 R4 R5 write", e, n);
        chk("R5 starts", nstart, 1);
        chk("R5 stops", nstop, 1);
        chk("R10 sda edges while scl high", nhi, 2);
        chk("R9 no error", nack_err, 0);
        chk("R10 scl period min", pmin, 4 * (int'(clk_div) + 1));
        chk("R10 scl period max", pmax, 4 * (int'(clk_div) + 1));
    endtask

    task automatic t_read(input logic [6:0] dev, input logic [1:0] len,
                          input logic [23:0] ia, input logic [7:0] rdv);
        logic [7:0] e [8];
        int n = 0;
        launch(1'b1, dev, len, ia, 8'h00, -1, rdv);
        wait_done();
        if (len != 2'd0) begin
            e[n++] = {dev, 1'b0};
            for (int k = int'(len); k >= 1; k--) e[n++] = ia[8*(k-1) +: 8];
        end
        e[n++] = {dev, 1'b1};
        check_bytes(len != 2'd0 ? "R4 R6 read" : "R3 R7 read", e, n);
        chk(len != 2'd0 ? "R6 starts" : "R7 starts", nstart, (len != 2'd0) ? 2 : 1);
        chk("R8 stops", nstop, 1);
        chk("R10 sda edges while scl high", nhi, (len != 2'd0) ? 3 : 2);
        chk("R8 master nack", m_ack, 1);
        chk("R8 rd_data", rd_data, rdv);
        chk("R10 scl period max", pmax, 4 * (int'(clk_div) + 1));
        repeat (100) @(negedge clk);
        chk("R8 rd_data held", rd_data, rdv);
    endtask

    task automatic t_nack(input logic rd, input logic [1:0] len, input int idx);
        launch(rd, 7'h2B, len, 24'hC0FFEE, 8'h77, idx, 8'h00);
        wait_done();
        chk("R9 bytes before abort", nlog, idx + 1);
        chk("R9 stop after refusal", nstop, 1);
        chk("R9 single start", nstart, 1);
        chk("R9 nack_err set", nack_err, 1);
        repeat (30) @(negedge clk);
        chk("R9 nack_err sticky", nack_err, 1);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] e [8];
        launch(1'b0, 7'h11, 2'd1, 24'h000042, 8'h5A, -1, 8'h00);
        repeat (150) @(negedge clk);
        rd_req = 1'b1; dev_addr = 7'h7F; iaddr_len = 2'd3; wr_data = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        e[0] = {7'h11, 1'b0}; e[1] = 8'h42; e[2] = 8'h5A;
        check_bytes("R2 busy start ignored", e, 3);
        chk("R2 single start", nstart, 1);
        repeat (40) @(negedge clk);
        chk("R2 no queued transaction", busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_write(7'h50, 2'd0, 24'h000000, 8'hA5);
        t_write(7'h50, 2'd3, 24'h123456, 8'h3C);
        t_write(7'h1E, 2'd1, 24'hABCD9E, 8'h81);
        t_read(7'h68, 2'd0, 24'h000000, 8'hC3);
        t_read(7'h50, 2'd2, 24'h991234, 8'h5E);
        t_read(7'h33, 2'd3, 24'hFEDCBA, 8'h01);
        t_nack(1'b0, 2'd2, 1);
        t_write(7'h22, 2'd2, 24'h00BEEF, 8'h10);
        t_nack(1'b1, 2'd0, 0);
        t_nack(1'b1, 2'd3, 3);
        t_busy_ignore();
        clk_div = 12'd0;
        t_write(7'h05, 2'd1, 24'h000077, 8'hE1);
        clk_div = 12'd6;
        t_read(7'h44, 2'd1, 24'h0000F0, 8'h96);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule